// File: doc/BRIEF.md
# Edge/Level Interrupt Controller, Single Bank

This block gathers 32 active-low interrupt lines into two processor requests: a normal request (`irq_req`) and a fast request (`fiq_req`). Each line has its own configuration word: a 5-bit priority, a sensitivity choice and a routing choice. The sensitivity is either falling edge or low level. The routing sends the line to one of the two requests. A pending register records which lines have arrived. A mask register blocks lines from taking part in arbitration. The lowest priority value wins. Among equal priorities, the higher line number wins.

Each request output has an arm flag. When an armed output sees at least one eligible line, it latches the winning line number, raises its request and disarms. The output then stays high and keeps that number until software writes the matching control bit. That write drops the output and arms it again. On the following cycle the output evaluates afresh.

Software reaches the block through a single-cycle register port with word addresses: a write strobe, a read strobe, an address and write data. Every access completes in the cycle it is presented, so the port has no back-pressure and no handshake. Read data is registered and appears one cycle after the read strobe.

The register offsets are:

| Offset | Register |
|---|---|
| 0x00 | Pending register |
| 0x04 | Mask register |
| 0x10 | Normal-request source code |
| 0x14 | Fast-request source code |
| 0x18 | Control register |
| 0x1C + 4·n | Configuration word for line n |
| 0x9C | Software-set register |

Top module: `line_intc`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF. The pending register, every configuration word and both source codes read 0. Both request outputs are low, and both outputs are armed.
- R2: The configuration word for line n sits at offset 0x1C+4·n and is laid out as follows: bits [6:2] hold the priority, bit 1 selects sensitivity (0 = falling edge, 1 = low level) and bit 0 selects routing (0 = normal request, 1 = fast request). Unused bits are dropped on write and read back as zero.
- R3: An edge line becomes pending only on a high-to-low transition of its input. While the input is held low it does not become pending again. A later rise of the input leaves the pending bit unchanged.
- R4: A level line is pending whenever its input is low. When its input returns high, its pending bit clears on the clock edge that samples the rise.
- R5: Only lines that are pending, unmasked (mask bit 0) and routed to an output take part in that output's arbitration. The lowest priority value wins, and a tie goes to the highest line number.
- R6: An armed output with an eligible line rises on the clock edge after the line becomes pending and latches the winner into its source code. It then stays high, with that code unchanged, until it is re-armed.
- R7: A write to offset 0x18 drops the normal request when bit 0 is set and the fast request when bit 1 is set, and arms it again. On the next clock edge the re-armed output fires again if an eligible line exists.
- R8: A write to offset 0x00 ANDs the pending register with the written value. A bit is kept regardless of the written value when its line is level-sensitive and its input is still low.
- R9: A read of offset 0x10 (normal) or 0x14 (fast) returns the latched line number in bits [4:0]. If that line is edge-sensitive, the read also clears its pending bit. A level line's pending bit is kept.
- R10: A write to offset 0x9C acts only on the lowest set bit of the written value. That line becomes pending as if its input had fallen.
- R11: Reads of offsets not listed in these requirements return 0, and writes to them change no register. Offset 0x18 also reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in_n | input | 32 | Interrupt lines, asserted low, sampled on clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
Two of this block's functions can act on one pending bit in the same cycle.

The first pair is a pending-register clear and a level line whose input is still low. The bench writes zeros to the pending register while the line is held low, then reads the bit back and expects it kept.

The second pair is a re-arm and an arbitration that already has candidates waiting. The bench gives a higher-priority line a pending bit while the output is held. It then expects the output to drop for exactly one cycle after the control write and to come back with the new winner. A random phase sets fresh priorities, routings, masks and input patterns on every round, and checks each winner against a model of the requirements built in the bench.

// File: rtl/line_intc_pkg.sv
package line_intc_pkg;
  // word offsets (byte address >> 2)
  localparam int WORD_PEND     = 0;
  localparam int WORD_MASK     = 1;
  localparam int WORD_CODE_IRQ = 4;
  localparam int WORD_CODE_FIQ = 5;
  localparam int WORD_CTRL     = 6;
  localparam int WORD_LVL_BASE = 7;
  localparam int WORD_SWSET    = 39;
  // configuration word fields
  localparam int CFG_ROUTE_BIT = 0;
  localparam int CFG_SENS_BIT  = 1;
  localparam int CFG_PRIO_LSB  = 2;
  // request outputs: index 0 normal, index 1 fast
  localparam int NUM_OUT       = 2;
endpackage

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] act,
  input  logic [NLINES-1:0] lvl,
  input  logic              wr_and,
  input  logic [NLINES-1:0] wr_data,
  input  logic [NLINES-1:0] sw_set,
  input  logic [NLINES-1:0] rd_clr,
  output logic [NLINES-1:0] pend
);
  logic [NLINES-1:0] in_q;
  logic [NLINES-1:0] pend_nx;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic arrive, sw_arrive, lvl_drop, wr_drop, clr;
    // edge line needs an inactive previous sample; level line arrives while low
    assign arrive    = act[i] & (lvl[i] | ~in_q[i]);
    assign sw_arrive = sw_set[i] & (lvl[i] | ~in_q[i]);
    assign lvl_drop  = lvl[i] & in_q[i] & ~act[i];
    assign wr_drop   = wr_and & ~wr_data[i] & ~(lvl[i] & act[i]);
    assign clr       = lvl_drop | wr_drop | rd_clr[i];
    assign pend_nx[i] = arrive | sw_arrive | (pend[i] & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
      pend <= '0;
    end else begin
      in_q <= act;
      pend <= pend_nx;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter int LIDX_W = 5
) (
  input  logic [NLINES-1:0]             elig,
  input  logic [NLINES-1:0][PRIO_W-1:0] prio,
  output logic                          any,
  output logic [LIDX_W-1:0]             win
);
  logic [PRIO_W-1:0] best;

  // ascending scan with <= lets the higher index take a tie
  always_comb begin
    best = '1;
    win  = '0;
    any  = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      if (elig[i] && (prio[i] <= best)) begin
        best = prio[i];
        win  = LIDX_W'(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_out_gate.sv
module intc_out_gate #(
  parameter int LIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rearm,
  input  logic              any,
  input  logic [LIDX_W-1:0] win,
  output logic              req,
  output logic [LIDX_W-1:0] code
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      req   <= 1'b0;
      code  <= '0;
    end else if (rearm) begin
      armed <= 1'b1;
      req   <= 1'b0;
    end else if (armed && any) begin
      armed <= 1'b0;
      req   <= 1'b1;
      code  <= win;
    end
  end
endmodule

// File: rtl/line_intc.sv
module line_intc
  import line_intc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_in_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int LIDX_W = $clog2(NLINES);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [NLINES-1:0] act_w, pend_w, mask_q, lvl_q, fiq_sel_q;
  logic [NLINES-1:0][PRIO_W-1:0] prio_q;
  logic [NLINES-1:0] sw_vec, rd_clr, wr_low;
  logic              pend_we, mask_we, lvl_rng;
  logic [LIDX_W-1:0] lvl_idx;
  logic [NUM_OUT-1:0]              any_w, req_w, rearm_w;
  logic [NUM_OUT-1:0][LIDX_W-1:0]  win_w, code_w;
  logic [NUM_OUT-1:0][NLINES-1:0]  elig_w;
  logic [LIDX_W-1:0] irq_code_w, fiq_code_w;

  assign word    = reg_addr[ADDR_W-1:2];
  assign act_w   = ~line_in_n;
  assign pend_we = reg_wr && (word == WORD_W'(WORD_PEND));
  assign mask_we = reg_wr && (word == WORD_W'(WORD_MASK));
  assign lvl_rng = (word >= WORD_W'(WORD_LVL_BASE)) &&
                   (word <  WORD_W'(WORD_LVL_BASE + NLINES));
  assign lvl_idx = LIDX_W'(word - WORD_W'(WORD_LVL_BASE));
  assign wr_low  = reg_wdata[NLINES-1:0];

  // software set: isolate lowest set bit
  always_comb begin
    sw_vec = '0;
    if (reg_wr && (word == WORD_W'(WORD_SWSET)))
      sw_vec = wr_low & (~wr_low + 1'b1);
  end

  // source-code read consumes an edge line
  always_comb begin
    rd_clr = '0;
    for (int c = 0; c < NUM_OUT; c++) begin
      if (reg_rd && (word == WORD_W'(WORD_CODE_IRQ + c)))
        rd_clr[code_w[c]] = ~lvl_q[code_w[c]];
    end
  end

  // configuration and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q    <= '0;
      lvl_q     <= '0;
      fiq_sel_q <= '0;
      mask_q    <= '1;
    end else begin
      if (mask_we)
        mask_q <= wr_low;
      for (int i = 0; i < NLINES; i++) begin
        if (reg_wr && (word == WORD_W'(WORD_LVL_BASE + i))) begin
          prio_q[i]    <= reg_wdata[CFG_PRIO_LSB +: PRIO_W];
          lvl_q[i]     <= reg_wdata[CFG_SENS_BIT];
          fiq_sel_q[i] <= reg_wdata[CFG_ROUTE_BIT];
        end
      end
    end
  end

  intc_pend_bank #(.NLINES(NLINES)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .act     (act_w),
    .lvl     (lvl_q),
    .wr_and  (pend_we),
    .wr_data (wr_low),
    .sw_set  (sw_vec),
    .rd_clr  (rd_clr),
    .pend    (pend_w)
  );

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_out
    if (c == 0) begin : g_route
      assign elig_w[c] = pend_w & ~mask_q & ~fiq_sel_q;
    end else begin : g_route
      assign elig_w[c] = pend_w & ~mask_q & fiq_sel_q;
    end
    assign rearm_w[c] = reg_wr && (word == WORD_W'(WORD_CTRL)) && reg_wdata[c];

    intc_prio_pick #(.NLINES(NLINES), .PRIO_W(PRIO_W), .LIDX_W(LIDX_W)) u_pick (
      .elig (elig_w[c]),
      .prio (prio_q),
      .any  (any_w[c]),
      .win  (win_w[c])
    );

    intc_out_gate #(.LIDX_W(LIDX_W)) u_gate (
      .clk   (clk),
      .rst   (rst),
      .rearm (rearm_w[c]),
      .any   (any_w[c]),
      .win   (win_w[c]),
      .req   (req_w[c]),
      .code  (code_w[c])
    );
  end

  assign irq_req    = req_w[0];
  assign fiq_req    = req_w[1];
  assign irq_code_w = code_w[0];
  assign fiq_code_w = code_w[1];

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (word == WORD_W'(WORD_PEND))
        reg_rdata <= DATA_W'(pend_w);
      else if (word == WORD_W'(WORD_MASK))
        reg_rdata <= DATA_W'(mask_q);
      else if (word == WORD_W'(WORD_CODE_IRQ))
        reg_rdata <= DATA_W'(code_w[0]);
      else if (word == WORD_W'(WORD_CODE_FIQ))
        reg_rdata <= DATA_W'(code_w[1]);
      else if (lvl_rng)
        reg_rdata <= DATA_W'({prio_q[lvl_idx], lvl_q[lvl_idx], fiq_sel_q[lvl_idx]});
      else
        reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/line_intc_chk.sv
module line_intc_chk
  import line_intc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8,
  parameter int LIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] line_in_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] mask,
  input logic [NLINES-1:0] lvl,
  input logic [NLINES-1:0] fiq_sel,
  input logic [LIDX_W-1:0] irq_code,
  input logic [LIDX_W-1:0] fiq_code
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic ctrl_wr, sw_wr;
  logic [NLINES-1:0] elig_irq_q, elig_fiq_q;

  assign word    = reg_addr[ADDR_W-1:2];
  assign ctrl_wr = reg_wr && (word == WORD_W'(WORD_CTRL));
  assign sw_wr   = reg_wr && (word == WORD_W'(WORD_SWSET));

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_irq_q <= '0;
      elig_fiq_q <= '0;
    end else begin
      elig_irq_q <= pend & ~mask & ~fiq_sel;
      elig_fiq_q <= pend & ~mask & fiq_sel;
    end
  end

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    irq_req && !(ctrl_wr && reg_wdata[0]) |=> irq_req); // R6
  AST_FIQ_HELD: assert property (@(posedge clk) disable iff (rst)
    fiq_req && !(ctrl_wr && reg_wdata[1]) |=> fiq_req); // R6
  AST_IRQ_REARM_DROP: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && reg_wdata[0] |=> !irq_req); // R7
  AST_FIQ_REARM_DROP: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && reg_wdata[1] |=> !fiq_req); // R7
  AST_IRQ_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> elig_irq_q[irq_code]); // R5
  AST_FIQ_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq_req) |-> elig_fiq_q[fiq_code]); // R5

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
      $rose(line_in_n[i]) && lvl[i] && !sw_wr |=> !pend[i]); // R4
    AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
      $rose(line_in_n[i]) && !lvl[i] && pend[i] && !reg_wr && !reg_rd |=> pend[i]); // R3
  end
endmodule

bind line_intc line_intc_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W), .LIDX_W(LIDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_in_n (line_in_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_req   (irq_req),
  .fiq_req   (fiq_req),
  .pend      (pend_w),
  .mask      (mask_q),
  .lvl       (lvl_q),
  .fiq_sel   (fiq_sel_q),
  .irq_code  (irq_code_w),
  .fiq_code  (fiq_code_w)
);

// File: tb/line_intc_test.sv
`timescale 1ns/1ps
module line_intc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] line_in_n = '1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req, fiq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int prio_m [32];
  logic [31:0] route_m;

  always #2 clk = ~clk;

  line_intc uut (
    .clk(clk), .rst(rst), .line_in_n(line_in_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; line_in_n = '1;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] cfg_addr(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  // R5 model: lowest value wins, tie to highest line
  function automatic logic [31:0] exp_win(input logic [31:0] e);
    int best = 99;
    logic [31:0] w = 0;
    for (int i = 0; i < 32; i++)
      if (e[i] && prio_m[i] <= best) begin best = prio_m[i]; w = i; end
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, mk, drv, e;
    void'($urandom(32'd7321));
    do_reset();

    // R1 reset state
    chk("R1 irq_req", {31'd0, irq_req}, 0);
    chk("R1 fiq_req", {31'd0, fiq_req}, 0);
    rd(8'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R1 pending", d, 0);
    rd(cfg_addr(5), d); chk("R1 cfg5", d, 0);
    rd(8'h10, d); chk("R1 irq code", d, 0);

    // R2 layout and dropped bits
    wr(cfg_addr(9), 32'hFFFF_FF57);
    rd(cfg_addr(9), d); chk("R2 cfg9 readback", d, 32'h57);

    // R11 undefined offsets
    wr(8'h08, 32'h1234_5678);
    wr(8'hA0, 32'h0);
    rd(8'h08, d); chk("R11 read 0x08", d, 0);
    rd(8'h04, d); chk("R11 mask untouched", d, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R11 ctrl reads 0", d, 0);

    // R3 / R9 edge line 4, normal request
    do_reset();
    wr(cfg_addr(4), 32'h0C);
    wr(8'h04, ~(32'h1 << 4));
    line_in_n[4] = 1'b0;
    step(2);
    chk("R6 irq fires", {31'd0, irq_req}, 1);
    rd(8'h10, d); chk("R9 irq code", d, 4);
    rd(8'h00, d); chk("R9 edge cleared by code read", d & 32'h10, 0);
    step(3);
    rd(8'h00, d); chk("R3 held low no re-pend", d & 32'h10, 0);
    line_in_n[4] = 1'b1; step(2);
    line_in_n[4] = 1'b0; step(2);
    rd(8'h00, d); chk("R3 falling edge pends", d & 32'h10, 32'h10);
    line_in_n[4] = 1'b1; step(2);
    rd(8'h00, d); chk("R3 rise keeps pending", d & 32'h10, 32'h10);
    chk("R6 irq held", {31'd0, irq_req}, 1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R8 edge cleared by write", d & 32'h10, 0);
    wr(8'h18, 32'h1);
    chk("R7 irq dropped", {31'd0, irq_req}, 0);
    step(2);
    chk("R7 no refire when idle", {31'd0, irq_req}, 0);
    line_in_n[4] = 1'b0; step(2);
    chk("R6 fires after rearm", {31'd0, irq_req}, 1);

    // R4 / R8 / R9 level line 7 routed to fast request
    do_reset();
    wr(cfg_addr(7), 32'h07);
    wr(8'h04, ~(32'h1 << 7));
    line_in_n[7] = 1'b0;
    step(2);
    chk("R5 fiq fires", {31'd0, fiq_req}, 1);
    chk("R5 irq not routed", {31'd0, irq_req}, 0);
    rd(8'h14, d); chk("R9 fiq code", d, 7);
    rd(8'h00, d); chk("R9 level kept on read", d & 32'h80, 32'h80);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R8 level kept while low", d & 32'h80, 32'h80);
    line_in_n[7] = 1'b1; step(2);
    rd(8'h00, d); chk("R4 level released", d & 32'h80, 0);

    // R10 software set, then R8 AND
    wr(8'h9C, (32'h1 << 12) | (32'h1 << 20));
    rd(8'h00, d); chk("R10 lowest bit only", d, 32'h1 << 12);
    wr(8'h9C, 32'h1 << 20);
    wr(8'h00, ~(32'h1 << 12));
    rd(8'h00, d); chk("R8 AND write", d, 32'h1 << 20);

    // R5 tie, R6 hold, R7 re-arm with a waiting winner
    do_reset();
    wr(cfg_addr(2), 32'h12);
    wr(cfg_addr(10), 32'h12);
    wr(cfg_addr(1), 32'h02);
    wr(8'h04, ~32'h406);
    line_in_n[2] = 1'b0; line_in_n[10] = 1'b0;
    step(2);
    rd(8'h10, d); chk("R5 tie to higher line", d, 10);
    line_in_n[1] = 1'b0; step(2);
    rd(8'h10, d); chk("R6 code held", d, 10);
    wr(8'h18, 32'h1);
    chk("R7 drop one cycle", {31'd0, irq_req}, 0);
    step(1);
    chk("R7 refire", {31'd0, irq_req}, 1);
    rd(8'h10, d); chk("R5 lowest value wins", d, 1);
    wr(8'h04, ~32'h404);
    wr(8'h18, 32'h1);
    step(1);
    rd(8'h10, d); chk("R5 masked line skipped", d, 10);

    // random rounds with level lines, R5 / R6
    do_reset();
    for (int it = 0; it < 24; it++) begin
      line_in_n = '1; step(2);
      wr(8'h00, 32'h0);
      wr(8'h18, 32'h3);
      step(1);
      route_m = $urandom;
      for (int i = 0; i < 32; i++) begin
        prio_m[i] = (it == 1) ? 7 : int'($urandom % 32);
        wr(cfg_addr(i), 32'((prio_m[i] << 2) | 2 | int'(route_m[i])));
      end
      mk  = (it == 0) ? 32'h0 : $urandom;
      drv = (it == 0) ? 32'hFFFF_FFFF : $urandom;
      wr(8'h04, mk);
      line_in_n = ~drv;
      step(2);
      e = drv & ~mk & ~route_m;
      chk("R6 random irq level", {31'd0, irq_req}, {31'd0, |e});
      if (|e) begin rd(8'h10, d); chk("R5 random irq winner", d, exp_win(e)); end
      e = drv & ~mk & route_m;
      chk("R6 random fiq level", {31'd0, fiq_req}, {31'd0, |e});
      if (|e) begin rd(8'h14, d); chk("R5 random fiq winner", d, exp_win(e)); end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule